// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port shared memory and watches the enable and address of the left and right ports. When both ports are enabled at the same address, it grants the location to the port that settled there first. It pulls an active-low busy line low toward the other port and raises that port's write-inhibit toward the memory, so the losing port's writes are dropped inside the array. If both ports arrive on the same clock edge, the left port always wins. The grant stays with the winner until the winner drops its enable or moves to another address. Once the ports stop colliding, busy releases at the next edge.

A mode input picks the block's role. As a master it arbitrates and drives both busy lines. As a slave it drives nothing: it holds both busy outputs high and takes externally supplied busy inputs, which do nothing but inhibit writes on their port. This lets several arrays that share address decoding follow the decision of a single master. All outputs are registered and reflect the inputs sampled at the same clock edge.

Top module: `dpc_contention_arbiter`

## Requirements
- R1: While `rst` is high, and on the first edge it is sampled high, both busy outputs are 1 and both write-inhibits are 0, whatever the other inputs are.
- R2: A collision exists only when both enables are 1 and both addresses are equal. At any edge with no collision, both busy outputs are 1 after that edge.
- R3: On a collision where exactly one port kept the same enable (1) and address as at the previous edge, that settled port wins and the other port's busy goes to 0 after the edge.
- R4: On a collision with no current grant where both ports changed, or both stayed settled, the left port wins and the right busy output goes to 0.
- R5: A grant stays with its winner while the collision continues and the winner keeps its enable and address, even if a fresh tie would pick the other port.
- R6: The two busy outputs are never 0 at the same time.
- R7: In master mode (`master_mode`=1), each port's write-inhibit is 1 exactly when that port's busy output is 0, and the busy input pins have no effect on any output.
- R8: In slave mode (`master_mode`=0), both busy outputs are 1, and each port's write-inhibit after an edge equals the inverse of that port's busy input sampled at that edge.
- R9: Outputs change only at a clock edge, one register stage after the inputs that cause them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = follow busy inputs |
| l_en | input | 1 | Left port enable, active high |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port enable, active high |
| r_addr | input | ADDR_W | Right port address |
| l_busy_in_n | input | 1 | Left busy input, active low, used in slave mode |
| r_busy_in_n | input | 1 | Right busy input, active low, used in slave mode |
| l_busy_out_n | output | 1 | Left busy output, active low, driven in master mode |
| r_busy_out_n | output | 1 | Right busy output, active low, driven in master mode |
| l_wr_inhibit | output | 1 | Blocks left-port writes to the memory |
| r_wr_inhibit | output | 1 | Blocks right-port writes to the memory |

## Verification
The hardest case to reach is a grant held against the tie rule. The right port must win by being settled first, and then both ports must stay settled, so that a fresh arbitration would hand the location to the left port. The stimulus table first releases the left port and holds the right one at the address. It then re-enables the left port at the same address and repeats that vector one more cycle. A second sequence switches to slave mode during a live collision and then back to master, so arbitration restarts with both ports already settled.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int unsigned NPORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/dpc_port_track.sv
// Remembers one port's previous enable/address and flags a port that has
// stayed on the same location across the last edge.
module dpc_port_track #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              settled
);
  logic              en_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en;
      addr_q <= addr;
    end
  end

  assign settled = en && en_q && (addr == addr_q);
endmodule

// File: rtl/dpc_grant_fsm.sv
// Holds the current owner of a contested location and computes the next one.
module dpc_grant_fsm
  import dpc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   master_mode,
  input  logic   hit,
  input  logic   settled_l,
  input  logic   settled_r,
  output owner_e owner_d
);
  owner_e owner_q;
  owner_e fresh;

  // Fresh decision: a settled port beats a newcomer, otherwise left wins.
  always_comb begin
    if (settled_r && !settled_l) fresh = OWN_RIGHT;
    else                         fresh = OWN_LEFT;
  end

  always_comb begin
    if (!master_mode || !hit) begin
      owner_d = OWN_NONE;
    end else begin
      unique case (owner_q)
        OWN_LEFT:  owner_d = settled_l ? OWN_LEFT  : fresh;
        OWN_RIGHT: owner_d = settled_r ? OWN_RIGHT : fresh;
        default:   owner_d = fresh;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= owner_d;
  end
endmodule

// File: rtl/dpc_busy_drive.sv
// Registered busy and write-inhibit outputs, one slice per port.
module dpc_busy_drive
  import dpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  owner_e            owner_d,
  input  logic [NPORTS-1:0] busy_in_n,
  output logic [NPORTS-1:0] busy_out_n,
  output logic [NPORTS-1:0] wr_inhibit
);
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam owner_e RIVAL = (p == PORT_L) ? OWN_RIGHT : OWN_LEFT;
    logic lost;
    assign lost = (owner_d == RIVAL);

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_out_n[p] <= 1'b1;
        wr_inhibit[p] <= 1'b0;
      end else if (master_mode) begin
        busy_out_n[p] <= !lost;
        wr_inhibit[p] <= lost;
      end else begin
        busy_out_n[p] <= 1'b1;
        wr_inhibit[p] <= !busy_in_n[p];
      end
    end
  end
endmodule

// File: rtl/dpc_contention_arbiter.sv
module dpc_contention_arbiter
  import dpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in_n,
  input  logic              r_busy_in_n,
  output logic              l_busy_out_n,
  output logic              r_busy_out_n,
  output logic              l_wr_inhibit,
  output logic              r_wr_inhibit
);
  logic [NPORTS-1:0]              en_v;
  logic [NPORTS-1:0][ADDR_W-1:0]  addr_v;
  logic [NPORTS-1:0]              settled_v;
  logic [NPORTS-1:0]              busy_in_v;
  logic [NPORTS-1:0]              busy_out_v;
  logic [NPORTS-1:0]              inhibit_v;
  logic                           hit;
  owner_e                         owner_d;

  assign en_v[PORT_L]      = l_en;
  assign en_v[PORT_R]      = r_en;
  assign addr_v[PORT_L]    = l_addr;
  assign addr_v[PORT_R]    = r_addr;
  assign busy_in_v[PORT_L] = l_busy_in_n;
  assign busy_in_v[PORT_R] = r_busy_in_n;

  for (genvar p = 0; p < NPORTS; p++) begin : g_trk
    dpc_port_track #(.ADDR_W(ADDR_W)) trk_i (
      .clk     (clk),
      .rst     (rst),
      .en      (en_v[p]),
      .addr    (addr_v[p]),
      .settled (settled_v[p])
    );
  end

  assign hit = (&en_v) && (addr_v[PORT_L] == addr_v[PORT_R]);

  dpc_grant_fsm fsm_i (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .hit         (hit),
    .settled_l   (settled_v[PORT_L]),
    .settled_r   (settled_v[PORT_R]),
    .owner_d     (owner_d)
  );

  dpc_busy_drive drv_i (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .owner_d     (owner_d),
    .busy_in_n   (busy_in_v),
    .busy_out_n  (busy_out_v),
    .wr_inhibit  (inhibit_v)
  );

  assign l_busy_out_n = busy_out_v[PORT_L];
  assign r_busy_out_n = busy_out_v[PORT_R];
  assign l_wr_inhibit = inhibit_v[PORT_L];
  assign r_wr_inhibit = inhibit_v[PORT_R];
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_busy_in_n,
  input logic              r_busy_in_n,
  input logic              l_busy_out_n,
  input logic              r_busy_out_n,
  input logic              l_wr_inhibit,
  input logic              r_wr_inhibit
);
  logic same_loc;
  assign same_loc = l_en && r_en && (l_addr == r_addr);

  assert_busy_excl_R6: assert property (@(posedge clk) disable iff (rst)
    l_busy_out_n || r_busy_out_n);

  assert_release_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(same_loc)) |-> (l_busy_out_n && r_busy_out_n));

  assert_master_inhibit_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(master_mode)) |->
      ((l_wr_inhibit == !l_busy_out_n) && (r_wr_inhibit == !r_busy_out_n)));

  assert_slave_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(master_mode)) |-> (l_busy_out_n && r_busy_out_n));

  assert_slave_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(master_mode)) |->
      ((l_wr_inhibit == !$past(l_busy_in_n)) && (r_wr_inhibit == !$past(r_busy_in_n))));

  assert_reset_idle_R1: assert property (@(posedge clk)
    $past(rst) |-> (l_busy_out_n && r_busy_out_n && !l_wr_inhibit && !r_wr_inhibit));
endmodule

bind dpc_contention_arbiter dpc_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .master_mode  (master_mode),
  .l_en         (l_en),
  .l_addr       (l_addr),
  .r_en         (r_en),
  .r_addr       (r_addr),
  .l_busy_in_n  (l_busy_in_n),
  .r_busy_in_n  (r_busy_in_n),
  .l_busy_out_n (l_busy_out_n),
  .r_busy_out_n (r_busy_out_n),
  .l_wr_inhibit (l_wr_inhibit),
  .r_wr_inhibit (r_wr_inhibit)
);

// File: tb/dpc_contention_arbiter_tb_top.sv
module dpc_contention_arbiter_tb_top;
  localparam int unsigned AW = 13;

  typedef struct packed {
    logic          ms;
    logic          el;
    logic [AW-1:0] al;
    logic          er;
    logic [AW-1:0] ar;
    logic          bl;
    logic          br;
    logic [3:0]    xp;   // {l_busy_out_n, r_busy_out_n, l_wr_inhibit, r_wr_inhibit}
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1, 0, 0, 0, 0, 1, 1, 4'b1100, 2},  // R2 idle
    '{1, 1, 5, 0, 0, 1, 1, 4'b1100, 2},  // R2 one port only
    '{1, 1, 5, 1, 5, 1, 1, 4'b1001, 3},  // R3 left settled first
    '{1, 1, 5, 1, 5, 1, 1, 4'b1001, 5},  // R5 hold
    '{1, 1, 5, 1, 6, 1, 1, 4'b1100, 2},  // R2 addresses differ
    '{1, 1, 5, 1, 5, 1, 1, 4'b1001, 3},  // R3 right returns, left settled
    '{1, 0, 5, 1, 5, 1, 1, 4'b1100, 2},  // R2 left drops enable
    '{1, 1, 5, 1, 5, 1, 1, 4'b0110, 3},  // R3 right settled first
    '{1, 1, 5, 1, 5, 1, 1, 4'b0110, 5},  // R5 right keeps grant against tie rule
    '{1, 0, 5, 0, 5, 1, 1, 4'b1100, 2},  // R2 both drop
    '{1, 1, 9, 1, 9, 1, 1, 4'b1001, 4},  // R4 simultaneous arrival
    '{1, 1, 7, 1, 7, 1, 1, 4'b1001, 4},  // R4 both move together
    '{1, 1, 7, 1, 7, 0, 0, 4'b1001, 7},  // R7 busy pins ignored in master
    '{0, 1, 7, 1, 7, 0, 1, 4'b1110, 8},  // R8 slave, left pin low
    '{0, 1, 7, 1, 7, 1, 0, 4'b1101, 8},  // R8 slave, right pin low
    '{0, 1, 7, 1, 7, 0, 0, 4'b1111, 8},  // R8 slave, both pins low
    '{1, 1, 7, 1, 7, 1, 1, 4'b1001, 4},  // R4 back to master, both settled
    '{1, 1, 1, 1, 2, 1, 1, 4'b1100, 2},  // R2 no collision
    '{1, 1, 1, 1, 1, 1, 1, 4'b1001, 3}   // R3 right joins settled left
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          master_mode = 1'b1;
  logic          l_en = 1'b0, r_en = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic          l_busy_out_n, r_busy_out_n, l_wr_inhibit, r_wr_inhibit;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #5 clk = ~clk;

  dpc_contention_arbiter #(.ADDR_W(AW)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .master_mode  (master_mode),
    .l_en         (l_en),
    .l_addr       (l_addr),
    .r_en         (r_en),
    .r_addr       (r_addr),
    .l_busy_in_n  (l_busy_in_n),
    .r_busy_in_n  (r_busy_in_n),
    .l_busy_out_n (l_busy_out_n),
    .r_busy_out_n (r_busy_out_n),
    .l_wr_inhibit (l_wr_inhibit),
    .r_wr_inhibit (r_wr_inhibit)
  );

  function automatic logic [3:0] outs();
    return {l_busy_out_n, r_busy_out_n, l_wr_inhibit, r_wr_inhibit};
  endfunction

  task automatic check(input string req, input string what, input logic [3:0] act,
                       input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic ms, input logic el, input logic [AW-1:0] al,
                       input logic er, input logic [AW-1:0] ar,
                       input logic bl, input logic br);
    @(negedge clk);
    master_mode = ms; l_en = el; l_addr = al; r_en = er; r_addr = ar;
    l_busy_in_n = bl; r_busy_in_n = br;
  endtask

  initial begin
    // R1: reset with a collision already present on the inputs
    drive(1, 1, 3, 1, 3, 0, 0);
    @(posedge clk); #1;
    check("R1", "outputs in reset", outs(), 4'b1100);
    @(posedge clk); #1;
    check("R1", "outputs held in reset", outs(), 4'b1100);
    drive(1, 0, 0, 0, 0, 1, 1);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R1", "idle after reset", outs(), 4'b1100);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ms, VECS[i].el, VECS[i].al, VECS[i].er, VECS[i].ar,
            VECS[i].bl, VECS[i].br);
      @(posedge clk); #1;
      check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d", i), outs(), VECS[i].xp);
      check("R6", $sformatf("busy exclusive vector %0d", i),
            {3'b000, (!l_busy_out_n && !r_busy_out_n)}, 4'b0000);
    end

    // R9: output waits for the edge
    drive(1, 0, 0, 0, 0, 1, 1);
    @(posedge clk); #1;
    drive(1, 1, 12, 1, 12, 1, 1);
    #1;
    check("R9", "no change before edge", outs(), 4'b1100);
    @(posedge clk); #1;
    check("R9", "change after edge", outs(), 4'b1001);

    // R1: reset during a held grant clears it
    drive(1, 1, 12, 1, 12, 1, 1);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R1", "reset clears grant", outs(), 4'b1100);
    drive(1, 1, 12, 1, 12, 1, 1);
    rst = 1'b0;
    @(posedge clk); #1;
    check("R4", "first edge after reset is a tie", outs(), 4'b1001);

    // R7: busy pins toggled in master have no effect
    drive(1, 1, 12, 1, 12, 0, 1);
    @(posedge clk); #1;
    check("R7", "left pin low ignored", outs(), 4'b1001);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule